// File: doc/BRIEF.md
# DVFS Mailbox Responder

This block models the management side of a single-word mailbox through which a host core reads and changes per-core frequency levels. The host places a 32-bit request into the mailbox register with the completion flag cleared, then sets a doorbell bit in a separate control register. The responder latches the request, waits a fixed number of cycles, and then executes it. It runs the request against a small table of frequency levels and a set of DVFS feature flags. It writes the return code into the command field and the result into the value field, and it sets the completion flag.

A configuration port loads the frequency of each level, the number of valid levels and the index of the first boost level. Levels at or above the boost index are boost levels. Only the DVFS feature is implemented. Sensor and fan requests are answered as unsupported.

Top module: `dvfs_mailbox_resp`

## Requirements
- R1: After reset the mailbox reads 0x80000000, meaning complete is 1 and every other field is 0. The control register reads 0. The current level is DEF_BOOST-1, and the DVFS flags are all 0.
- R2: A control-register write with bit 10 set, made while the mailbox complete bit (bit 31) is 0 and no request is in flight, starts a request. Complete reads 0 for LATENCY-1 cycles after the write edge and reads 1 after exactly LATENCY edges. Bit 10 of the control register always reads back 0.
- R3: While a request is in flight, mailbox writes are ignored. A doorbell is also ignored while the mailbox complete bit is 1, and the mailbox then keeps its value.
- R4: The response word keeps id (bits 3:0), info (bits 7:4) and extra (bit 30) from the request. It carries the return code in bits 29:24 (0 ok, 1 error, 2 unsupported, 3 invalid argument) and the result in bits 23:8. The result is 0 unless the return code is ok.
- R5: Command 0x01 returns ok with the nonzero VERSION constant.
- R6: Command 0x02 with id 2 returns the 4-bit DVFS flags (bit 0 enable, bit 1 boost). With id 0 or 1 it returns ok with 0. Command 0x03 with id 2 stores value bits 3:0 as the flags. With id 0 or 1, command 0x03 returns 2. With any id above 2, both commands return 3.
- R7: Command 0x09 returns the level count and command 0x10 returns the boost index.
- R8: Command 0x11 with info 0 returns the frequency of the level whose index is in the value field. It returns 3 if info is not 0 or if the index is at or above the level count.
- R9: Command 0x12 returns the current level's frequency when info is 0 and the current level index when info is 1. Any other info value returns 3.
- R10: Command 0x13 checks its conditions in this order: info not 1 gives 3, enable flag clear gives 1, index at or above the count gives 3, index at or above the boost index with the boost flag clear gives 3. Otherwise the current level takes the index and the command returns ok.
- R11: Commands 0x04 to 0x08 and every other unlisted code return 2.
- R12: A table write sets one level's frequency. A limit write sets the count, clamped to MAX_LEVELS, and the boost index, clamped to the count. It also sets the current level to the boost index minus 1, or to 0 if the boost index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the mailbox, 1 selects the control register |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| cfg_tbl_we | input | 1 | Level frequency write strobe |
| cfg_tbl_idx | input | LVL_W | Level index to write |
| cfg_tbl_freq | input | 16 | Frequency for that level |
| cfg_lim_we | input | 1 | Count and boost index write strobe |
| cfg_lim_count | input | CNT_W | Number of valid levels |
| cfg_lim_boost | input | CNT_W | First boost level index |

## Verification
The bench goes after the order of checks in the set-frequency command. A design that tested the range before the enable flag would report 3 where 1 is due. A design that ignored the boost flag would let the host reach a boost level while boost is off. Mailbox writes during a request and doorbells with no pending request are aimed at too: a responder that accepted them would answer a corrupted request or complete an empty one. The limit clamps and the current-level reset on a limit write are checked through commands 0x09, 0x10 and 0x12, where an unclamped count or a stale level index shows up directly.

// File: rtl/dvfs_mbx_pkg.sv
package dvfs_mbx_pkg;

    localparam int VAL_W    = 16;
    localparam int BELL_BIT = 10;

    typedef struct packed {
        logic       done;
        logic       extra;
        logic [5:0] cmd;
        logic [15:0] val;
        logic [3:0] info;
        logic [3:0] id;
    } mbx_word_t;

    typedef enum logic [1:0] {
        RC_OK     = 2'd0,
        RC_FAIL   = 2'd1,
        RC_UNSUP  = 2'd2,
        RC_BADARG = 2'd3
    } rc_e;

    localparam logic [5:0] OP_VERSION   = 6'h01;
    localparam logic [5:0] OP_FEAT_GET  = 6'h02;
    localparam logic [5:0] OP_FEAT_SET  = 6'h03;
    localparam logic [5:0] OP_LVL_NUM   = 6'h09;
    localparam logic [5:0] OP_BOOST_IDX = 6'h10;
    localparam logic [5:0] OP_LVL_FREQ  = 6'h11;
    localparam logic [5:0] OP_FREQ_GET  = 6'h12;
    localparam logic [5:0] OP_FREQ_SET  = 6'h13;

    localparam logic [3:0] FEAT_DVFS  = 4'd2;
    localparam logic [3:0] TYPE_FREQ  = 4'd0;
    localparam logic [3:0] TYPE_LEVEL = 4'd1;

    localparam int FLG_EN    = 0;
    localparam int FLG_BOOST = 1;

endpackage

// File: rtl/dvfs_level_table.sv
module dvfs_level_table #(
    parameter int MAX_LEVELS = 16,
    parameter int DEF_LEVELS = 12,
    parameter int DEF_BOOST  = 10,
    parameter int BASE_FREQ  = 800,
    parameter int STEP_FREQ  = 100,
    parameter int LVL_W      = 4,
    parameter int CNT_W      = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tbl_we,
    input  logic [LVL_W-1:0]       tbl_idx,
    input  logic [15:0]            tbl_freq,
    input  logic                   lim_we,
    input  logic [CNT_W-1:0]       lim_count,
    input  logic [CNT_W-1:0]       lim_boost,
    input  logic [LVL_W-1:0]       rd_a_idx,
    output logic [15:0]            rd_a_freq,
    input  logic [LVL_W-1:0]       rd_b_idx,
    output logic [15:0]            rd_b_freq,
    output logic [CNT_W-1:0]       lvl_count,
    output logic [CNT_W-1:0]       boost_idx,
    output logic [LVL_W-1:0]       load_level
);

    typedef struct packed {
        logic [MAX_LEVELS-1:0][15:0] freq;
        logic [CNT_W-1:0]            count;
        logic [CNT_W-1:0]            boost;
    } tbl_t;

    tbl_t q, n;
    logic [CNT_W-1:0] count_c;
    logic [CNT_W-1:0] boost_c;

    // clamp count to the table size and the boost index to the count
    always_comb begin
        count_c = (lim_count > CNT_W'(MAX_LEVELS)) ? CNT_W'(MAX_LEVELS) : lim_count;
        boost_c = (lim_boost > count_c) ? count_c : lim_boost;
        load_level = (boost_c == '0) ? '0 : LVL_W'(boost_c - CNT_W'(1));
    end

    always_comb begin
        n = q;
        if (tbl_we) begin
            n.freq[tbl_idx] = tbl_freq;
        end
        if (lim_we) begin
            n.count = count_c;
            n.boost = boost_c;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MAX_LEVELS; i++) begin
                q.freq[i] <= 16'(BASE_FREQ + i * STEP_FREQ);
            end
            q.count <= CNT_W'(DEF_LEVELS);
            q.boost <= CNT_W'(DEF_BOOST);
        end else begin
            q <= n;
        end
    end

    assign rd_a_freq = q.freq[rd_a_idx];
    assign rd_b_freq = q.freq[rd_b_idx];
    assign lvl_count = q.count;
    assign boost_idx = q.boost;

endmodule

// File: rtl/dvfs_mbx_exec.sv
module dvfs_mbx_exec
    import dvfs_mbx_pkg::*;
#(
    parameter int          LVL_W   = 4,
    parameter int          CNT_W   = 5,
    parameter logic [15:0] VERSION = 16'h0102
) (
    input  logic [3:0]       req_id,
    input  logic [3:0]       req_info,
    input  logic [15:0]      req_val,
    input  logic [5:0]       req_cmd,
    input  logic [3:0]       flags,
    input  logic [CNT_W-1:0] lvl_count,
    input  logic [CNT_W-1:0] boost_idx,
    input  logic [LVL_W-1:0] cur_level,
    input  logic [15:0]      sel_freq,
    input  logic [15:0]      cur_freq,
    output rc_e              rc,
    output logic [15:0]      result,
    output logic             flags_we,
    output logic [3:0]       flags_new,
    output logic             level_we,
    output logic [LVL_W-1:0] level_new
);

    logic idx_over;
    logic idx_boost;

    assign idx_over  = req_val >= VAL_W'(lvl_count);
    assign idx_boost = req_val >= VAL_W'(boost_idx);

    always_comb begin
        rc        = RC_OK;
        result    = '0;
        flags_we  = 1'b0;
        flags_new = req_val[3:0];
        level_we  = 1'b0;
        level_new = req_val[LVL_W-1:0];
        case (req_cmd)
            OP_VERSION: begin
                result = VERSION;
            end
            OP_FEAT_GET: begin
                if (req_id == FEAT_DVFS) begin
                    result = VAL_W'(flags);
                end else if (req_id > FEAT_DVFS) begin
                    rc = RC_BADARG;
                end
            end
            OP_FEAT_SET: begin
                if (req_id == FEAT_DVFS) begin
                    flags_we = 1'b1;
                end else if (req_id > FEAT_DVFS) begin
                    rc = RC_BADARG;
                end else begin
                    rc = RC_UNSUP;
                end
            end
            OP_LVL_NUM: begin
                result = VAL_W'(lvl_count);
            end
            OP_BOOST_IDX: begin
                result = VAL_W'(boost_idx);
            end
            OP_LVL_FREQ: begin
                if (req_info != TYPE_FREQ || idx_over) begin
                    rc = RC_BADARG;
                end else begin
                    result = sel_freq;
                end
            end
            OP_FREQ_GET: begin
                if (req_info == TYPE_FREQ) begin
                    result = cur_freq;
                end else if (req_info == TYPE_LEVEL) begin
                    result = VAL_W'(cur_level);
                end else begin
                    rc = RC_BADARG;
                end
            end
            OP_FREQ_SET: begin
                if (req_info != TYPE_LEVEL) begin
                    rc = RC_BADARG;
                end else if (!flags[FLG_EN]) begin
                    rc = RC_FAIL;
                end else if (idx_over) begin
                    rc = RC_BADARG;
                end else if (idx_boost && !flags[FLG_BOOST]) begin
                    rc = RC_BADARG;
                end else begin
                    level_we = 1'b1;
                end
            end
            default: begin
                // sensor/fan codes and anything unknown
                rc = RC_UNSUP;
            end
        endcase
    end

endmodule

// File: rtl/dvfs_mailbox_resp.sv
module dvfs_mailbox_resp
    import dvfs_mbx_pkg::*;
#(
    parameter int          MAX_LEVELS = 16,
    parameter int          LATENCY    = 4,
    parameter int          DEF_LEVELS = 12,
    parameter int          DEF_BOOST  = 10,
    parameter int          BASE_FREQ  = 800,
    parameter int          STEP_FREQ  = 100,
    parameter logic [15:0] VERSION    = 16'h0102,
    localparam int         LVL_W      = $clog2(MAX_LEVELS),
    localparam int         CNT_W      = $clog2(MAX_LEVELS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             cfg_tbl_we,
    input  logic [LVL_W-1:0] cfg_tbl_idx,
    input  logic [15:0]      cfg_tbl_freq,
    input  logic             cfg_lim_we,
    input  logic [CNT_W-1:0] cfg_lim_count,
    input  logic [CNT_W-1:0] cfg_lim_boost
);

    localparam int LAT_W = $clog2(LATENCY + 1);
    localparam logic [LVL_W-1:0] RST_LEVEL = LVL_W'(DEF_BOOST - 1);

    typedef struct packed {
        mbx_word_t        mbx;
        logic [31:0]      ctl;
        logic [3:0]       flags;
        logic [LVL_W-1:0] level;
        logic             busy;
        logic [LAT_W-1:0] cnt;
    } state_t;

    state_t q, n;

    logic [15:0]      sel_freq;
    logic [15:0]      cur_freq;
    logic [CNT_W-1:0] lvl_count;
    logic [CNT_W-1:0] boost_idx;
    logic [LVL_W-1:0] load_level;
    rc_e              rc;
    logic [15:0]      result;
    logic             flags_we;
    logic [3:0]       flags_new;
    logic             level_we;
    logic [LVL_W-1:0] level_new;
    logic             fire;

    dvfs_level_table #(
        .MAX_LEVELS (MAX_LEVELS),
        .DEF_LEVELS (DEF_LEVELS),
        .DEF_BOOST  (DEF_BOOST),
        .BASE_FREQ  (BASE_FREQ),
        .STEP_FREQ  (STEP_FREQ),
        .LVL_W      (LVL_W),
        .CNT_W      (CNT_W)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .tbl_we     (cfg_tbl_we),
        .tbl_idx    (cfg_tbl_idx),
        .tbl_freq   (cfg_tbl_freq),
        .lim_we     (cfg_lim_we),
        .lim_count  (cfg_lim_count),
        .lim_boost  (cfg_lim_boost),
        .rd_a_idx   (q.mbx.val[LVL_W-1:0]),
        .rd_a_freq  (sel_freq),
        .rd_b_idx   (q.level),
        .rd_b_freq  (cur_freq),
        .lvl_count  (lvl_count),
        .boost_idx  (boost_idx),
        .load_level (load_level)
    );

    dvfs_mbx_exec #(
        .LVL_W   (LVL_W),
        .CNT_W   (CNT_W),
        .VERSION (VERSION)
    ) u_exec (
        .req_id    (q.mbx.id),
        .req_info  (q.mbx.info),
        .req_val   (q.mbx.val),
        .req_cmd   (q.mbx.cmd),
        .flags     (q.flags),
        .lvl_count (lvl_count),
        .boost_idx (boost_idx),
        .cur_level (q.level),
        .sel_freq  (sel_freq),
        .cur_freq  (cur_freq),
        .rc        (rc),
        .result    (result),
        .flags_we  (flags_we),
        .flags_new (flags_new),
        .level_we  (level_we),
        .level_new (level_new)
    );

    assign fire = q.busy && (q.cnt == '0);

    always_comb begin
        n = q;
        // host register writes
        if (reg_wr && reg_sel) begin
            n.ctl = reg_wdata;
            n.ctl[BELL_BIT] = 1'b0;
            if (reg_wdata[BELL_BIT] && !q.busy && !q.mbx.done) begin
                n.busy = 1'b1;
                n.cnt  = LAT_W'(LATENCY - 1);
            end
        end else if (reg_wr && !q.busy) begin
            n.mbx = mbx_word_t'(reg_wdata);
        end
        // request in flight
        if (q.busy) begin
            if (!fire) begin
                n.cnt = q.cnt - LAT_W'(1);
            end else begin
                n.busy     = 1'b0;
                n.mbx.done = 1'b1;
                n.mbx.cmd  = {4'b0000, rc};
                n.mbx.val  = result;
                if (flags_we) begin
                    n.flags = flags_new;
                end
                if (level_we) begin
                    n.level = level_new;
                end
            end
        end
        // limit reload has priority over a level set in the same cycle
        if (cfg_lim_we) begin
            n.level = load_level;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q          <= '0;
            q.mbx.done <= 1'b1;
            q.level    <= RST_LEVEL;
        end else begin
            q <= n;
        end
    end

    assign reg_rdata = reg_sel ? q.ctl : q.mbx;

    logic             chk_busy;
    logic [31:0]      chk_mbx;
    logic [LVL_W-1:0] chk_level;
    logic [CNT_W-1:0] chk_count;
    assign chk_busy  = q.busy;
    assign chk_mbx   = q.mbx;
    assign chk_level = q.level;
    assign chk_count = lvl_count;

endmodule

// File: rtl/dvfs_mbx_checker.sv
module dvfs_mbx_checker #(
    parameter int LATENCY = 4,
    parameter int LVL_W   = 4,
    parameter int CNT_W   = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic [31:0]      mbx,
    input logic [LVL_W-1:0] level,
    input logic [CNT_W-1:0] count,
    input logic             reg_wr,
    input logic             reg_sel,
    input logic             bell,
    input logic             lim_we
);

    int run;

    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            run <= 0;
        end else begin
            run <= run + 1;
        end
    end

    AST_DONE_ON_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run == LATENCY) && mbx[31]); // R2

    AST_IDLE_BELL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel && bell && mbx[31] && !busy) |=> !busy); // R3

    AST_REQ_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mbx)); // R3

    AST_RC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (mbx[29:24] <= 6'd3)); // R4

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (count != '0) |-> ({1'b0, level} < count)); // R10

    AST_LEVEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !lim_we) |=> $stable(level)); // R12

endmodule

bind dvfs_mailbox_resp dvfs_mbx_checker #(
    .LATENCY (LATENCY),
    .LVL_W   (LVL_W),
    .CNT_W   (CNT_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (chk_busy),
    .mbx     (chk_mbx),
    .level   (chk_level),
    .count   (chk_count),
    .reg_wr  (reg_wr),
    .reg_sel (reg_sel),
    .bell    (reg_wdata[10]),
    .lim_we  (cfg_lim_we)
);

// File: tb/test_dvfs_mailbox_resp.sv
module test_dvfs_mailbox_resp;

    localparam int MAXL  = 16;
    localparam int LAT   = 4;
    localparam int LVL_W = 4;
    localparam int CNT_W = 5;
    localparam logic [15:0] VER = 16'h0102;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_wr = 1'b0;
    logic             reg_sel = 1'b0;
    logic [31:0]      reg_wdata = '0;
    logic [31:0]      reg_rdata;
    logic             cfg_tbl_we = 1'b0;
    logic [LVL_W-1:0] cfg_tbl_idx = '0;
    logic [15:0]      cfg_tbl_freq = '0;
    logic             cfg_lim_we = 1'b0;
    logic [CNT_W-1:0] cfg_lim_count = '0;
    logic [CNT_W-1:0] cfg_lim_boost = '0;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    int m_freq [MAXL];
    int m_count, m_boost, m_level;
    logic [3:0] m_flags;

    always #10 clk = ~clk;

    dvfs_mailbox_resp #(.LATENCY(LAT), .VERSION(VER)) i_dvfs_mailbox_resp (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cfg_tbl_we(cfg_tbl_we), .cfg_tbl_idx(cfg_tbl_idx), .cfg_tbl_freq(cfg_tbl_freq),
        .cfg_lim_we(cfg_lim_we), .cfg_lim_count(cfg_lim_count), .cfg_lim_boost(cfg_lim_boost)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_sel = 1'b0;
    endtask

    function automatic string tag_of(input logic [5:0] c);
        case (c)
            6'h01: return "R5";
            6'h02, 6'h03: return "R6";
            6'h09, 6'h10: return "R7";
            6'h11: return "R8";
            6'h12: return "R9";
            6'h13: return "R10";
            default: return "R11";
        endcase
    endfunction

    // reference model of request execution, updates the model state
    task automatic model(input logic [3:0] id, input logic [3:0] info, input logic [15:0] val,
                         input logic [5:0] c, output int rc, output int res);
        rc = 0; res = 0;
        case (c)
            6'h01: res = VER;
            6'h02: if (id == 2) res = m_flags; else if (id > 2) rc = 3;
            6'h03: if (id == 2) m_flags = val[3:0]; else if (id > 2) rc = 3; else rc = 2;
            6'h09: res = m_count;
            6'h10: res = m_boost;
            6'h11: if (info != 0 || val >= m_count) rc = 3; else res = m_freq[val];
            6'h12: if (info == 0) res = m_freq[m_level];
                   else if (info == 1) res = m_level; else rc = 3;
            6'h13: begin
                if (info != 1) rc = 3;
                else if (!m_flags[0]) rc = 1;
                else if (val >= m_count) rc = 3;
                else if (val >= m_boost && !m_flags[1]) rc = 3;
                else m_level = val;
            end
            default: rc = 2;
        endcase
    endtask

    task automatic run_req(input logic [3:0] id, input logic [3:0] info, input logic [15:0] val,
                           input logic [5:0] c, input logic ext);
        int rc, res;
        logic [31:0] exp;
        write_reg(1'b0, {1'b0, ext, c, val, info, id});
        model(id, info, val, c, rc, res);
        exp = {1'b1, ext, 6'(rc), 16'(res), info, id};
        write_reg(1'b1, 32'h0000_0400);
        repeat (LAT - 1) @(negedge clk);
        check("R2 not done early", {31'b0, reg_rdata[31]}, 32'h0);
        @(negedge clk);
        check({"R4 ", tag_of(c)}, reg_rdata, exp);
    endtask

    task automatic set_limits(input int cnt, input int bst);
        @(negedge clk);
        cfg_lim_we = 1'b1; cfg_lim_count = CNT_W'(cnt); cfg_lim_boost = CNT_W'(bst);
        @(negedge clk);
        cfg_lim_we = 1'b0;
        m_count = (cnt > MAXL) ? MAXL : cnt;
        m_boost = (bst > m_count) ? m_count : bst;
        m_level = (m_boost == 0) ? 0 : m_boost - 1;
    endtask

    initial begin
        logic [5:0] ops [14];
        logic [31:0] saved;
        void'($urandom(32'd2718));
        ops = '{6'h01, 6'h02, 6'h03, 6'h03, 6'h05, 6'h09, 6'h10, 6'h11,
                6'h12, 6'h13, 6'h13, 6'h13, 6'h08, 6'h3f};
        for (int i = 0; i < MAXL; i++) m_freq[i] = 800 + 100 * i;
        m_count = 12; m_boost = 10; m_level = 9; m_flags = 4'h0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 mailbox", reg_rdata, 32'h8000_0000);
        reg_sel = 1'b1; #1;
        check("R1 control", reg_rdata, 32'h0);
        reg_sel = 1'b0;
        run_req(4'd0, 4'd1, 16'd0, 6'h12, 1'b0);    // R1 level = boost-1
        run_req(4'd2, 4'd0, 16'd0, 6'h02, 1'b0);    // R1 flags zero

        // R3 doorbell with complete=1 is ignored
        saved = reg_rdata;
        write_reg(1'b1, 32'h0000_0401);
        repeat (LAT + 2) @(negedge clk);
        check("R3 idle doorbell", reg_rdata, saved);
        reg_sel = 1'b1; #1;
        check("R2 bell reads 0", reg_rdata, 32'h0000_0001);
        reg_sel = 1'b0;

        // R3 mailbox writes during a request are ignored
        write_reg(1'b0, {1'b0, 1'b1, 6'h01, 16'h0000, 4'h3, 4'h5});
        write_reg(1'b1, 32'h0000_0400);
        write_reg(1'b0, 32'h0013_ffff);
        repeat (LAT + 1) @(negedge clk);
        check("R3 busy write ignored", reg_rdata, {1'b1, 1'b1, 6'h00, VER, 4'h3, 4'h5});

        // R10 ordering corners
        run_req(4'd0, 4'd1, 16'd3, 6'h13, 1'b0);    // enable clear -> 1
        run_req(4'd0, 4'd0, 16'd3, 6'h13, 1'b0);    // bad type -> 3
        run_req(4'd2, 4'd0, 16'h0001, 6'h03, 1'b0); // R6 enable only
        run_req(4'd0, 4'd1, 16'd12, 6'h13, 1'b0);   // index = count -> 3
        run_req(4'd0, 4'd1, 16'd10, 6'h13, 1'b0);   // boost w/o flag -> 3
        run_req(4'd0, 4'd1, 16'd9, 6'h13, 1'b0);    // ok
        run_req(4'd2, 4'd0, 16'h0003, 6'h03, 1'b1); // R6 enable+boost
        run_req(4'd0, 4'd1, 16'd11, 6'h13, 1'b0);   // boost ok
        run_req(4'd0, 4'd0, 16'd0, 6'h12, 1'b0);    // R9 freq
        run_req(4'd7, 4'd0, 16'd0, 6'h02, 1'b0);    // R6 bad id
        run_req(4'd1, 4'd0, 16'd1, 6'h03, 1'b0);    // R6 fan set unsup
        run_req(4'd0, 4'd0, 16'd0, 6'h04, 1'b0);    // R11

        // R12 configuration port
        @(negedge clk);
        cfg_tbl_we = 1'b1; cfg_tbl_idx = 4'd4; cfg_tbl_freq = 16'h1234;
        @(negedge clk);
        cfg_tbl_we = 1'b0; m_freq[4] = 16'h1234;
        run_req(4'd0, 4'd0, 16'd4, 6'h11, 1'b0);
        set_limits(20, 25);                         // clamps 16/16
        run_req(4'd0, 4'd0, 16'd0, 6'h09, 1'b0);
        run_req(4'd0, 4'd0, 16'd0, 6'h10, 1'b0);
        run_req(4'd0, 4'd1, 16'd0, 6'h12, 1'b0);
        set_limits(6, 0);
        run_req(4'd0, 4'd1, 16'd0, 6'h12, 1'b0);    // level 0
        run_req(4'd0, 4'd0, 16'd6, 6'h11, 1'b0);    // R8 out of range
        set_limits(12, 10);

        // constrained random requests
        for (int k = 0; k < 300; k++) begin
            logic [5:0] c;
            logic [15:0] v;
            logic [3:0] id;
            logic [3:0] inf;
            c   = ops[$urandom % 14];
            id  = (c == 6'h03 || c == 6'h02) ? 4'($urandom % 4) : 4'($urandom % 16);
            inf = 4'($urandom % 3);
            v   = 16'($urandom % 18);
            if (c == 6'h03 && ($urandom % 4) != 0) id = 4'd2;
            if (c == 6'h13 && ($urandom % 3) != 0) inf = 4'd1;
            if (c == 6'h11 && ($urandom % 3) != 0) inf = 4'd0;
            run_req(id, inf, v, c, 1'($urandom % 2));
            if (k == 150) set_limits(8, 5);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule